// File: doc/BRIEF.md
# Two-Phase Interleaved PWM Generator

This block drives two pulse-width-modulated outputs from a single free-running period counter. Both outputs use the same period and the same duty code. The second output's compare window is moved by exactly half a period relative to the first. When the two outputs are summed through a resistor pair, the result switches at twice the single-channel rate and with a smaller step. This makes the downstream low-pass filter easier to design. The summing resistors and the filter sit outside this block.

The period is a power of two, `2**CNT_W` clocks. The duty code is `CNT_W+1` bits wide, so the full-scale value `2**CNT_W` can be written. The block samples the duty code once per period, on the last count, and applies the new value to both phases together from the next period on. A one-cycle period-start pulse marks the clock in which the outputs show count position 0. Both phase outputs and the start pulse are registered, so every output changes one clock after the counter position it shows.

Top module: `interleaved_pwm_pair`

## Requirements
- R1: While `rst` is high, `phase_a`, `phase_b` and `period_start` are low at the next clock. After release, the counter restarts at position 0 and the active duty is 0.
- R2: The period is `2**CNT_W` clocks. Output cycle k after reset release shows position p = (k-1) mod `2**CNT_W`. In that cycle `phase_a` is high exactly when p < active duty.
- R3: `phase_b` is high exactly when (p + `2**(CNT_W-1)`) mod `2**CNT_W` < active duty. This is the same rule as phase A, shifted by half a period.
- R4: `duty_code` is sampled only on the clock where the position is `2**CNT_W-1`. The value sampled there becomes the active duty for both phases for the whole next period. Changes at other times have no effect on the outputs until that sample.
- R5: `period_start` is high for exactly one cycle per period, in the cycle where the outputs show position 0.
- R6: An active duty of 0 keeps both outputs low. An active duty of `2**CNT_W` or more keeps both outputs high for the whole period.
- R7: With active duty below half scale, `phase_a` and `phase_b` are never high in the same cycle.
- R8: With active duty above half scale, at least one of the two outputs is high in every cycle.
- R9: With active duty exactly at half scale, exactly one output is high in every cycle.
- R10: Over each full period, each output is high for min(active duty, `2**CNT_W`) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_code | input | CNT_W+1 | Requested duty in counts, sampled at the period end |
| phase_a | output | 1 | First PWM phase, registered |
| phase_b | output | 1 | Second PWM phase, half a period later, registered |
| period_start | output | 1 | One-cycle marker for position 0 |

## Verification
The embedded assertions check the following on every cycle:
- the overlap rules for duty below, at and above half scale;
- the all-low behaviour at zero duty;
- the counter wrap;
- the one-cycle width of the start pulse;
- the rule that the active duty moves only at a wrap.

Only the bench scenarios can show that the exact high positions of each phase and the half-period shift are correct. They also show the per-period high counts, that a duty change in mid-period waits for the boundary, and that the block recovers from a reset in mid-run. The bench does this by comparing every output cycle against an independent position-and-duty model across many duty codes, including zero, half scale, full scale and values above full scale.

// File: rtl/ipwm_pkg.sv
package ipwm_pkg;
  // Number of interleaved phases produced from the shared counter.
  localparam int unsigned NUM_PHASES = 2;

  // Counter offset for phase index idx: the phases are spread evenly over the period.
  function automatic int unsigned phase_offset(input int unsigned idx, input int unsigned cnt_w);
    phase_offset = (idx << cnt_w) / NUM_PHASES;
  endfunction
endpackage

// File: rtl/ipwm_period_cnt.sv
module ipwm_period_cnt #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] LAST_POS = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      start_q <= (cnt_q == '0);
    end
  end

  assign cnt_o   = cnt_q;
  assign wrap_o  = (cnt_q == LAST_POS);
  assign start_o = start_q;

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST_POS) |=> (cnt_q == '0));

  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
endmodule

// File: rtl/ipwm_duty_hold.sv
module ipwm_duty_hold #(
  parameter int unsigned DUTY_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [DUTY_W-1:0] act_o
);
  logic [DUTY_W-1:0] act_q;

  always_ff @(posedge clk) begin
    if (rst)         act_q <= '0;
    else if (wrap_i) act_q <= duty_i;
  end

  assign act_o = act_q;

  // R4
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap_i |=> $stable(act_q));
endmodule

// File: rtl/ipwm_phase_cmp.sv
module ipwm_phase_cmp #(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned OFFSET = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W:0]   act_i,
  output logic             ph_o
);
  localparam logic [CNT_W-1:0] OFF_W = OFFSET[CNT_W-1:0];

  logic [CNT_W-1:0] pos;
  logic             ph_q;

  assign pos = cnt_i + OFF_W;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= 1'b0;
    else     ph_q <= ({1'b0, pos} < act_i);
  end

  assign ph_o = ph_q;

  // R6
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (rst)
    (act_i == '0) |=> !ph_q);
endmodule

// File: rtl/interleaved_pwm_pair.sv
module interleaved_pwm_pair #(
  parameter int unsigned CNT_W = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CNT_W:0] duty_code,
  output logic           phase_a,
  output logic           phase_b,
  output logic           period_start
);
  localparam int unsigned DUTY_W = CNT_W + 1;
  localparam logic [DUTY_W-1:0] HALF = DUTY_W'(1 << (CNT_W - 1));

  logic [CNT_W-1:0]  cnt_w;
  logic              wrap_w;
  logic [DUTY_W-1:0] act_w;
  logic [ipwm_pkg::NUM_PHASES-1:0] ph_w;

  ipwm_period_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .cnt_o(cnt_w), .wrap_o(wrap_w), .start_o(period_start)
  );

  ipwm_duty_hold #(.DUTY_W(DUTY_W)) i_duty (
    .clk(clk), .rst(rst), .wrap_i(wrap_w), .duty_i(duty_code), .act_o(act_w)
  );

  for (genvar g = 0; g < ipwm_pkg::NUM_PHASES; g++) begin : g_phase
    ipwm_phase_cmp #(
      .CNT_W (CNT_W),
      .OFFSET(ipwm_pkg::phase_offset(g, CNT_W))
    ) i_cmp (
      .clk(clk), .rst(rst), .cnt_i(cnt_w), .act_i(act_w), .ph_o(ph_w[g])
    );
  end

  assign phase_a = ph_w[0];
  assign phase_b = ph_w[1];

  // R7
  low_duty_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(act_w) < HALF) |-> !(phase_a && phase_b));

  // R8
  high_duty_cover_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(act_w) > HALF && !$past(rst)) |-> (phase_a || phase_b));

  // R9
  half_duty_one_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(act_w) == HALF && !$past(rst)) |-> $onehot({phase_a, phase_b}));
endmodule

// File: tb/test_interleaved_pwm_pair.sv
`timescale 1ns/1ps
module test_interleaved_pwm_pair;
  localparam int CNT_W = 6;
  localparam int P     = 1 << CNT_W;
  localparam int HALF  = P / 2;

  typedef struct { bit a; bit b; bit s; int eff; } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [CNT_W:0] duty_code = '0;
  logic           phase_a, phase_b, period_start;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  exp_t q[$];

  interleaved_pwm_pair #(.CNT_W(CNT_W)) i_interleaved_pwm_pair (
    .clk(clk), .rst(rst), .duty_code(duty_code),
    .phase_a(phase_a), .phase_b(phase_b), .period_start(period_start)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: predicts each output cycle from position and active duty.
  int pos = 0;
  int eff = 0;
  always @(posedge clk) begin
    if (rst) begin
      pos = 0;
      eff = 0;
    end else begin
      exp_t it;
      it.a   = pos < eff;
      it.b   = ((pos + HALF) % P) < eff;
      it.s   = (pos == 0);
      it.eff = eff;
      q.push_back(it);
      if (pos == P - 1) eff = int'(duty_code);  // R4 sample point
      pos = (pos + 1) % P;
    end
  end

  // Monitor: compares outputs away from the active edge.
  int cnt_a = 0, cnt_b = 0, per_eff = 0;
  bit have_per = 1'b0;
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      if (it.s) begin
        if (have_per) begin
          int want;
          want = (per_eff < P) ? per_eff : P;
          chk(cnt_a == want, "R10 phase_a highs per period", cnt_a, want);
          chk(cnt_b == want, "R10 phase_b highs per period", cnt_b, want);
        end
        have_per = 1'b1;
        per_eff  = it.eff;
        cnt_a = 0;
        cnt_b = 0;
      end
      cnt_a += int'(phase_a);
      cnt_b += int'(phase_b);
      chk(phase_a == it.a, "R2 phase_a (duty per R4)", phase_a, it.a);
      chk(phase_b == it.b, "R3 phase_b (duty per R4)", phase_b, it.b);
      chk(period_start == it.s, "R5 period_start", period_start, it.s);
      if (it.eff == 0 || it.eff >= P)
        chk(phase_a == it.a && phase_b == it.a, "R6 rail duty", {phase_a, phase_b}, {it.a, it.a});
      if (it.eff < HALF)
        chk(!(phase_a && phase_b), "R7 no overlap", {phase_a, phase_b}, 0);
      else if (it.eff > HALF)
        chk(phase_a || phase_b, "R8 always one high", {phase_a, phase_b}, 1);
      else
        chk(phase_a ^ phase_b, "R9 exactly one high", {phase_a, phase_b}, 1);
    end else if (rst) begin
      have_per = 1'b0;
      chk({phase_a, phase_b, period_start} == 3'b000, "R1 reset outputs low",
          {phase_a, phase_b, period_start}, 0);
    end
  end

  task automatic drive(input bit r, input int d);
    @(posedge clk);
    #1;
    rst = r;
    duty_code = (CNT_W+1)'(d);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    int codes[12] = '{0, 10, 32, 50, 64, 100, 127, 1, 63, 31, 33, 20};
    drive(1'b1, 0);
    repeat (4) drive(1'b1, 0);
    drive(1'b0, 0);
    foreach (codes[i]) begin
      drive(1'b0, codes[i]);            // applied mid-period, waits for wrap (R4)
      repeat (3 * P + 7) @(posedge clk);
    end
    // Toggle the request well inside a period; only the boundary value counts (R4).
    drive(1'b0, 45);
    repeat (5) @(posedge clk);
    drive(1'b0, 12);
    repeat (2 * P) @(posedge clk);
    // Mid-run reset (R1): restart from position 0 with zero duty.
    drive(1'b1, 40);
    repeat (3) drive(1'b1, 40);
    drive(1'b0, 40);
    repeat (3 * P) @(posedge clk);
    drive(1'b1, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule